// File: doc/BRIEF.md
# Lane Power Sequencer

This block brings a group of serial output lanes up or down one lane at a time. Software writes a control word that carries a go bit, a walk direction, the target power state and an inter-lane gap. The block accepts the word only when idle. It switches the first lane in the same clock edge that accepts the word. It then waits the programmed gap before each further lane and finally raises a sticky done flag. The busy output reads back as the go bit still being set, so software polls it until the sequence has cleared it.

A separate lane-count write selects which lane pad enables are driven. The enables are cumulative from lane 0. Lanes outside the enabled group are held powered down. When the target is power-down, the pad calibration circuit is also forced into power-down. The gap counts ticks of a prescaler, `TICK_DIV` clocks each, which restarts at every lane step. A slow single-ended-style link would program a gap of 15 and a fast serial link a gap of 1.

Top module: `lane_pwr_seq`

## Requirements
- R1: After reset every lane is off (`lane_on` = 0), no lane is enabled (`lane_en` = 0), `seq_done` = 1, `seq_busy` = 0, `seq_err` = 0 and `cal_pd` = 1.
- R2: A lane-count write of 0, 1, 2 or 4 sets `lane_en` to 0000, 0001, 0011 or 1111, where bit i is lane i.
- R3: A lane-count write of any other value (3, 5, 6, 7) is rejected: `lane_en` and `lane_on` keep their values.
- R4: A lane-count write while busy is ignored. A lane-count write in the same cycle as an accepted go takes effect, and it sets the length of that sequence.
- R5: `ctl_wr` with `ctl_go` = 1 while idle is accepted. From that edge on, `seq_busy` = 1 and `seq_done` = 0. `ctl_wr` with `ctl_go` = 0 has no effect.
- R6: With `ctl_walk_down` = 1 the sequence visits lanes from the highest enabled lane down to lane 0. With `ctl_walk_down` = 0 it visits them from lane 0 upward. Each visited lane takes the value of `ctl_pwr_on`.
- R7: Step k (k = 0 first) lands k*(gap*TICK_DIV+1) cycles after the accepting edge. With N enabled lanes the sequence ends N*(gap*TICK_DIV+1) cycles after that edge, or 1 cycle after it when N = 0.
- R8: At the end of a sequence `seq_busy` falls and `seq_done` rises in the same edge. `seq_done` then stays set until the next accepted go.
- R9: A go written while busy leaves the running sequence unchanged and sets `seq_err`. `seq_err` stays set until reset.
- R10: An accepted power-down go (`ctl_pwr_on` = 0) sets `cal_pd`, and an accepted power-up go clears it.
- R11: A legal lane-count write that narrows the group switches off, in that same edge, every lane outside the new group. Those lanes stay off until they are enabled and sequenced again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_go | input | 1 | Go bit of the control word |
| ctl_walk_down | input | 1 | 1: highest lane first, 0: lane 0 first |
| ctl_pwr_on | input | 1 | Target lane state, 1 = powered |
| ctl_gap | input | GAP_W (4) | Inter-lane gap in prescaler ticks |
| cnt_wr | input | 1 | Lane-count write strobe |
| cnt_val | input | CNT_W (3) | Requested lane count |
| lane_on | output | NUM_LANES (4) | Per-lane power state |
| lane_en | output | NUM_LANES (4) | Per-lane pad enable from the lane count |
| cal_pd | output | 1 | Pad calibration power-down |
| seq_busy | output | 1 | Sequence running (go bit read back) |
| seq_done | output | 1 | Sticky completion flag |
| seq_err | output | 1 | Sticky go-while-busy flag |

## Verification
Two collisions matter here. The first is a go that lands on the very edge where a running sequence finishes: busy is still set on that edge, so the go must be dropped and the error flag raised. The bench drives a second go in the last busy cycle, then checks that the lane pattern and the done timing match the undisturbed sequence and that `seq_err` is set. The second is a lane-count write in the same cycle as an accepted go. The bench checks that the new group decides the number of steps and their lane order, cycle by cycle, against a model of R6 and R7.

// File: rtl/lps_pkg.sv
// Package: shared types of the lane power sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package lps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/lps_tick.sv
// Prescaler: one tick every TICK_DIV clocks, restarted by clr.
// Assumes: TICK_DIV >= 1; a tick is combinational on the last count.
module lps_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] presc;
            assign tick = (presc == PW'(TICK_DIV - 1));
            // Purpose: count clocks between ticks, restarting on clr.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)  presc <= '0;
                else if (tick)      presc <= '0;
                else                presc <= presc + PW'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/lps_lane_cfg.sv
// Lane-count register: decodes a legal count into a cumulative enable mask.
// Assumes: legal counts are 0 and powers of two up to NUM_LANES; writes are
// ignored while a sequence runs.
module lps_lane_cfg #(
    parameter int NUM_LANES = 4,
    parameter int CNT_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy,
    input  logic                 cnt_wr,
    input  logic [CNT_W-1:0]     cnt_val,
    output logic [CNT_W-1:0]     n_d,
    output logic [NUM_LANES-1:0] mask_d,
    output logic [NUM_LANES-1:0] mask_q
);
    logic [CNT_W-1:0] n_q;
    logic             cnt_legal;
    logic             take;

    // Purpose: legality of the requested count.
    always_comb begin
        cnt_legal = (cnt_val == '0) ||
                    ((cnt_val <= CNT_W'(NUM_LANES)) &&
                     ((cnt_val & (cnt_val - CNT_W'(1))) == '0));
    end

    assign take = cnt_wr && cnt_legal && !busy;
    assign n_d  = take ? cnt_val : n_q;

    // Purpose: cumulative mask of the next count.
    always_comb begin
        for (int i = 0; i < NUM_LANES; i++) begin
            mask_d[i] = (CNT_W'(i) < n_d);
        end
    end

    // Purpose: hold the accepted count and its mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q    <= '0;
            mask_q <= '0;
        end else begin
            n_q    <= n_d;
            mask_q <= mask_d;
        end
    end

    assert_bad_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !cnt_legal) |=> $stable(mask_q));
    assert_busy_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && busy) |=> $stable(mask_q));
endmodule

// File: rtl/lps_lane_bank.sv
// Lane state bank: one power bit per lane, set by sequencer steps and
// cleared for lanes leaving the enabled group.
// Assumes: at most one lane is stepped per cycle.
module lps_lane_bank #(
    parameter int NUM_LANES = 4,
    parameter int POS_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 apply_en,
    input  logic [POS_W-1:0]     apply_idx,
    input  logic                 apply_val,
    input  logic [NUM_LANES-1:0] mask_d,
    output logic [NUM_LANES-1:0] state
);
    logic [NUM_LANES-1:0] nxt;

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            assign nxt[g] = (apply_en && apply_idx == POS_W'(g)) ? apply_val : state[g];
        end
    endgenerate

    // Purpose: register lane states, dropping lanes outside the next mask.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= '0;
        else        state <= nxt & mask_d;
    end
endmodule

// File: rtl/lps_seq_fsm.sv
// Sequencer: accepts a go when idle, steps enabled lanes in the chosen
// order with a gap of ticks between steps, then raises sticky done.
// Assumes: n_d is the lane count in force from the accepting edge on.
module lps_seq_fsm #(
    parameter int CNT_W = 3,
    parameter int POS_W = 2,
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_go,
    input  logic             ctl_walk_down,
    input  logic             ctl_pwr_on,
    input  logic [GAP_W-1:0] ctl_gap,
    input  logic [CNT_W-1:0] n_d,
    input  logic             tick,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             cal_pd,
    output logic             apply_en,
    output logic [POS_W-1:0] apply_idx,
    output logic             apply_val,
    output logic             presc_clr
);
    import lps_pkg::*;

    seq_state_t       st;
    logic             dir_q, pwr_q;
    logic [GAP_W-1:0] gap_q, gcnt;
    logic [CNT_W-1:0] n_q;
    logic [POS_W-1:0] pos;
    logic [CNT_W-1:0] pos_ext;
    logic             accept, gap_over, last;

    assign busy     = (st != ST_IDLE);
    assign accept   = ctl_wr && ctl_go && !busy;
    assign pos_ext  = CNT_W'(pos);
    assign gap_over = (st == ST_WAIT) && (gcnt == gap_q);
    assign last     = (pos_ext == n_q - CNT_W'(1));

    // Purpose: choose which lane, if any, is stepped in this cycle.
    always_comb begin
        apply_en  = 1'b0;
        apply_idx = '0;
        apply_val = pwr_q;
        presc_clr = 1'b0;
        if (accept && n_d != '0) begin
            apply_en  = 1'b1;
            apply_idx = POS_W'(ctl_walk_down ? n_d - CNT_W'(1) : '0);
            apply_val = ctl_pwr_on;
            presc_clr = 1'b1;
        end else if (gap_over && !last) begin
            apply_en  = 1'b1;
            apply_idx = POS_W'(dir_q ? n_q - pos_ext - CNT_W'(2) : pos_ext + CNT_W'(1));
            presc_clr = 1'b1;
        end
    end

    // Purpose: sequence state, latched parameters and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            done   <= 1'b1;
            err    <= 1'b0;
            cal_pd <= 1'b1;
            dir_q  <= 1'b0;
            pwr_q  <= 1'b0;
            gap_q  <= '0;
            n_q    <= '0;
            pos    <= '0;
            gcnt   <= '0;
        end else begin
            if (ctl_wr && ctl_go && busy) err <= 1'b1;
            case (st)
                ST_IDLE: if (accept) begin
                    done   <= 1'b0;
                    dir_q  <= ctl_walk_down;
                    pwr_q  <= ctl_pwr_on;
                    gap_q  <= ctl_gap;
                    n_q    <= n_d;
                    pos    <= '0;
                    gcnt   <= '0;
                    cal_pd <= !ctl_pwr_on;
                    st     <= (n_d == '0) ? ST_FIN : ST_WAIT;
                end
                ST_WAIT: begin
                    if (gap_over) begin
                        if (last) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            pos  <= pos + POS_W'(1);
                            gcnt <= '0;
                        end
                    end else if (tick) begin
                        gcnt <= gcnt + GAP_W'(1);
                    end
                end
                default: begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                end
            endcase
        end
    end

    assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));
    assert_go_busy_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_go && busy) |=> err);
    assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && !done));
    assert_cal_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ctl_pwr_on) |=> cal_pd);
endmodule

// File: rtl/lane_pwr_seq.sv
// Top: lane power sequencer with go/done handshake, cumulative lane-count
// enables and a tick-based inter-lane gap.
// Assumes: NUM_LANES is a power of two; inputs are synchronous to clk.
module lane_pwr_seq #(
    parameter int NUM_LANES = 4,
    parameter int GAP_W     = 4,
    parameter int TICK_DIV  = 4,
    parameter int CNT_W     = $clog2(NUM_LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr,
    input  logic                 ctl_go,
    input  logic                 ctl_walk_down,
    input  logic                 ctl_pwr_on,
    input  logic [GAP_W-1:0]     ctl_gap,
    input  logic                 cnt_wr,
    input  logic [CNT_W-1:0]     cnt_val,
    output logic [NUM_LANES-1:0] lane_on,
    output logic [NUM_LANES-1:0] lane_en,
    output logic                 cal_pd,
    output logic                 seq_busy,
    output logic                 seq_done,
    output logic                 seq_err
);
    localparam int POS_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    logic [CNT_W-1:0]     n_d;
    logic [NUM_LANES-1:0] mask_d;
    logic                 tick, presc_clr, apply_en, apply_val;
    logic [POS_W-1:0]     apply_idx;

    lps_lane_cfg #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .busy(seq_busy), .cnt_wr(cnt_wr),
        .cnt_val(cnt_val), .n_d(n_d), .mask_d(mask_d), .mask_q(lane_en)
    );

    lps_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(presc_clr), .tick(tick)
    );

    lps_seq_fsm #(.CNT_W(CNT_W), .POS_W(POS_W), .GAP_W(GAP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_go(ctl_go),
        .ctl_walk_down(ctl_walk_down), .ctl_pwr_on(ctl_pwr_on),
        .ctl_gap(ctl_gap), .n_d(n_d), .tick(tick), .busy(seq_busy),
        .done(seq_done), .err(seq_err), .cal_pd(cal_pd),
        .apply_en(apply_en), .apply_idx(apply_idx), .apply_val(apply_val),
        .presc_clr(presc_clr)
    );

    lps_lane_bank #(.NUM_LANES(NUM_LANES), .POS_W(POS_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .apply_en(apply_en), .apply_idx(apply_idx),
        .apply_val(apply_val), .mask_d(mask_d), .state(lane_on)
    );

    assert_unused_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_on & ~lane_en) == '0);
    assert_one_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> ($countones(lane_on ^ $past(lane_on)) <= 1));
endmodule

// File: tb/test_lane_pwr_seq.sv
module test_lane_pwr_seq;
    localparam int TDIV = 4;
    localparam int NL   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, ctl_go = 1'b0, ctl_walk_down = 1'b0, ctl_pwr_on = 1'b0;
    logic [3:0] ctl_gap = '0;
    logic       cnt_wr = 1'b0;
    logic [2:0] cnt_val = '0;
    logic [3:0] lane_on, lane_en;
    logic       cal_pd, seq_busy, seq_done, seq_err;

    int tests = 0, fails = 0;
    logic [3:0] m_mask = '0, m_lanes = '0;
    logic       m_cal = 1'b1, m_err = 1'b0;

    always #10 clk = ~clk;

    lane_pwr_seq #(.NUM_LANES(NL), .GAP_W(4), .TICK_DIV(TDIV)) i_lane_pwr_seq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_go(ctl_go),
        .ctl_walk_down(ctl_walk_down), .ctl_pwr_on(ctl_pwr_on), .ctl_gap(ctl_gap),
        .cnt_wr(cnt_wr), .cnt_val(cnt_val), .lane_on(lane_on), .lane_en(lane_en),
        .cal_pd(cal_pd), .seq_busy(seq_busy), .seq_done(seq_done), .seq_err(seq_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] mask_of(input int n);
        return 4'((1 << n) - 1);
    endfunction

    function automatic bit legal(input int n);
        return (n == 0 || n == 1 || n == 2 || n == 4);
    endfunction

    // expected lanes t cycles after the accepting edge
    function automatic logic [3:0] exp_lanes(input logic [3:0] s, input int n, input bit dn,
                                             input bit on, input int gap, input int t);
        int per = gap * TDIV + 1;
        int a = t / per + 1;
        logic [3:0] r = s;
        if (a > n) a = n;
        for (int j = 0; j < a; j++) r[dn ? n - 1 - j : j] = on;
        return r & mask_of(n);
    endfunction

    function automatic int end_of(input int n, input int gap);
        return (n == 0) ? 1 : n * (gap * TDIV + 1);
    endfunction

    task automatic set_count(input int v, input string req);
        @(negedge clk);
        cnt_wr = 1'b1; cnt_val = 3'(v);
        @(negedge clk);
        cnt_wr = 1'b0;
        if (legal(v)) begin m_mask = mask_of(v); m_lanes = m_lanes & m_mask; end
        chk(req, "lane_en", lane_en, m_mask);
        chk(req, "lane_on", lane_on, m_lanes);
    endtask

    // newcnt < 0: no count write with go; inj_go/inj_cnt: cycle index to inject
    task automatic run_seq(input bit dn, input bit on, input int gap, input int newcnt,
                           input int inj_go, input int inj_cnt, input string req);
        int n, fin;
        logic [3:0] s;
        @(negedge clk);
        ctl_wr = 1'b1; ctl_go = 1'b1; ctl_walk_down = dn; ctl_pwr_on = on; ctl_gap = 4'(gap);
        if (newcnt >= 0) begin cnt_wr = 1'b1; cnt_val = 3'(newcnt); end
        if (newcnt >= 0 && legal(newcnt)) m_mask = mask_of(newcnt);
        m_lanes = m_lanes & m_mask;
        s = m_lanes;
        n = $countones(m_mask);
        fin = end_of(n, gap);
        m_cal = !on;
        for (int t = 0; t <= fin; t++) begin
            @(negedge clk);
            ctl_wr = 1'b0; ctl_go = 1'b0; cnt_wr = 1'b0;
            chk(req, "lane_on", lane_on, exp_lanes(s, n, dn, on, gap, t));
            chk(req, "seq_busy", seq_busy, (t < fin) ? 1 : 0);
            chk(req, "seq_done", seq_done, (t < fin) ? 0 : 1);
            chk("R10", "cal_pd", cal_pd, m_cal);
            chk("R4", "lane_en", lane_en, m_mask);
            if (t == inj_go) begin
                ctl_wr = 1'b1; ctl_go = 1'b1; ctl_walk_down = !dn; ctl_pwr_on = !on; ctl_gap = 4'd0;
            end
            if (t == inj_cnt) begin cnt_wr = 1'b1; cnt_val = 3'd1; end
        end
        m_lanes = exp_lanes(s, n, dn, on, gap, fin);
        if (inj_go >= 0) m_err = 1'b1;
        chk("R9", "seq_err", seq_err, m_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "lane_on", lane_on, 0);
        chk("R1", "lane_en", lane_en, 0);
        chk("R1", "seq_done", seq_done, 1);
        chk("R1", "seq_busy", seq_busy, 0);
        chk("R1", "seq_err", seq_err, 0);
        chk("R1", "cal_pd", cal_pd, 1);
        // R2 legal counts
        set_count(1, "R2"); set_count(2, "R2"); set_count(0, "R2"); set_count(4, "R2");
        // R3 illegal counts
        set_count(3, "R3"); set_count(5, "R3"); set_count(7, "R3");
        // R5 write without go
        @(negedge clk);
        ctl_wr = 1'b1; ctl_go = 1'b0; ctl_pwr_on = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
        chk("R5", "seq_busy", seq_busy, 0);
        chk("R5", "seq_done", seq_done, 1);
        chk("R5", "lane_on", lane_on, m_lanes);
        // R6 R7 power-up walking down, fast gap
        run_seq(1'b1, 1'b1, 1, -1, -1, -1, "R6");
        // R6 R7 power-down walking up, slow gap
        run_seq(1'b0, 1'b0, 15, -1, -1, -1, "R7");
        // R8 R9 go on the finishing edge
        run_seq(1'b1, 1'b1, 2, -1, end_of(4, 2) - 1, -1, "R8");
        // R9 go mid-sequence, R4 count write while busy
        run_seq(1'b0, 1'b0, 3, -1, 5, 7, "R9");
        // R4 count write with the go, R11 narrowing
        run_seq(1'b1, 1'b1, 0, 4, -1, -1, "R4");
        set_count(2, "R11");
        set_count(1, "R11");
        run_seq(1'b0, 1'b1, 1, 2, -1, -1, "R11");
        // R7 zero lanes
        run_seq(1'b0, 1'b0, 5, 0, -1, -1, "R7");
        // random mix
        for (int i = 0; i < 20; i++) begin
            int c = $urandom % 8;
            run_seq(1'($urandom), 1'($urandom), int'($urandom % 16),
                    ($urandom % 3 == 0) ? -1 : c, -1, -1, "R6");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule